// File: doc/BRIEF.md
# USB Control Register with Line Signaling

This block is the byte-wide control and status register of a full-speed USB serial interface engine, together with the logic that the register drives directly. A CPU writes the register through a single-cycle write port to enable the module, pick host or device operation, request bus reset or resume signaling, and clear the ping-pong bank state. The same byte, read back with one cycle of latency, carries two live receiver signals and a flag bit. In host mode the flag reports that the token engine is busy. In device mode it reports that transmission has been suspended after a SETUP token.

The block also keeps one even/odd bank bit for each endpoint and direction. Each bit toggles when a transaction completes, and each can be read through a probe port. It drives the transmit line directly: SE0 for bus reset, the K state for resume, and in host mode a low-speed end-of-packet once resume is released.

Top module: `usb_ctl_sig`

## Requirements
- R1: On a synchronous reset, `cpu_rdata` is 0x00, the line drive is released (`drv_oe`, `drv_dp` and `drv_dm` all 0), every bank bit is 0, and `sie_halt` and `sie_rst` are 0.
- R2: `cpu_rdata` is registered and reflects the inputs and state of the previous cycle. Bit 7 is `rx_diff` XOR `ls_en` (J state). Bit 6 is `rx_se0`. Bit 4 is bus reset, bit 3 is host mode, bit 2 is resume and bit 0 is enable, each as last written. Bit 1 always reads 0.
- R3: In device mode (bit 3 = 0), a `setup_rcvd` pulse sets the flag (bit 5), and `sie_halt` then reads 1. A write with bit 5 = 0 clears the flag. A write with bit 5 = 1 leaves it unchanged.
- R4: In host mode, bit 5 reads `token_busy`. Writes and `setup_rcvd` pulses leave the device suspend flag unchanged.
- R5: The line is driven to SE0 (`drv_oe`=1, `drv_dp`=0, `drv_dm`=0) exactly while both the reset bit and the host bit are 1. This takes priority over resume signaling. With host mode off, the reset bit drives nothing.
- R6: While the resume bit is 1, the line is driven to K: `drv_dp` = `ls_en` and `drv_dm` = NOT `ls_en`. Resume starts one cycle after the write.
- R7: When resume is cleared in host mode, the line shows SE0 for 2×`LS_BIT_CLKS` cycles, then J (`drv_dp` = NOT `ls_en`, `drv_dm` = `ls_en`) for `LS_BIT_CLKS` cycles, and is then released. When resume is cleared in device mode, the line is released on the next cycle.
- R8: When enabled (bit 0 = 1), an `xact_done` pulse toggles the bank bit selected by index {`xact_ep`, `xact_tx`}. When disabled, the pulse has no effect.
- R9: A write with bit 1 = 1 or bit 0 = 1 clears every bank bit to 0 (even bank). The clear wins over a toggle in the same cycle.
- R10: Every write with bit 0 = 1 raises `sie_rst` for exactly one cycle, in the cycle after the write.
- R11: `probe_odd` shows the bank bit {`probe_ep`, `probe_tx`} one cycle after the probe inputs are applied.
- R12: `usb_en` and `host_mode` follow bits 0 and 3 as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| rx_diff | input | 1 | Receiver differential level, 1 when D+ is above D- |
| rx_se0 | input | 1 | Receiver single-ended zero |
| ls_en | input | 1 | Low-speed polarity select |
| token_busy | input | 1 | Token engine busy (host mode) |
| setup_rcvd | input | 1 | SETUP token received pulse |
| sie_halt | output | 1 | Device transmit/receive suspended |
| sie_rst | output | 1 | One-cycle engine reset pulse |
| usb_en | output | 1 | Module enabled |
| host_mode | output | 1 | Host mode selected |
| xact_done | input | 1 | Transaction completed pulse |
| xact_ep | input | 4 | Endpoint of completed transaction |
| xact_tx | input | 1 | Direction of completed transaction, 1 for transmit |
| probe_ep | input | 4 | Bank probe endpoint |
| probe_tx | input | 1 | Bank probe direction |
| probe_odd | output | 1 | Probed bank bit |
| drv_oe | output | 1 | Line drive enable |
| drv_dp | output | 1 | D+ drive level |
| drv_dm | output | 1 | D- drive level |

## Verification
The bench measures the end-of-packet that follows resume by counting cycles. A counter that is off by one would lengthen or shorten the SE0 or the J phase, and swapped polarity would put out K in place of J. It also clears resume in device mode, where a design that ignores the host bit would append an end-of-packet that should not be there. The shared flag bit is exercised in both modes: a SETUP pulse in host mode must not arm suspend, and a write of 1 must not clear it. The bench also drives a bank clear and a toggle in the same cycle, and pulses transactions while the module is disabled. A wrong priority, or a missing enable gate, leaves a stale odd bank.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;

  typedef enum logic [1:0] {
    LN_IDLE    = 2'd0,
    LN_RESUME  = 2'd1,
    LN_EOP_SE0 = 2'd2,
    LN_EOP_J   = 2'd3
  } line_st_e;

  localparam int B_EN     = 0;
  localparam int B_ODDCLR = 1;
  localparam int B_RESUME = 2;
  localparam int B_HOST   = 3;
  localparam int B_BUSRST = 4;
  localparam int B_FLAG   = 5;

  typedef struct packed {
    logic busrst;
    logic host;
    logic resume;
    logic en;
  } ctl_t;

endpackage

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs
  import usb_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_we,
  input  logic [7:0] cpu_wdata,
  input  logic       rx_diff,
  input  logic       rx_se0,
  input  logic       ls_en,
  input  logic       token_busy,
  input  logic       setup_rcvd,
  output ctl_t       ctl,
  output logic       bank_clr,
  output logic       sie_rst,
  output logic       sie_halt,
  output logic [7:0] cpu_rdata
);

  ctl_t       ctl_q;
  logic       susp_q;
  logic       sie_rst_q;
  logic [7:0] rdata_q;
  logic       flag_view;

  // Host mode shows token activity; device mode shows the suspend flag.
  assign flag_view = ctl_q.host ? token_busy : susp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      susp_q    <= 1'b0;
      sie_rst_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (cpu_we) begin
        ctl_q.busrst <= cpu_wdata[B_BUSRST];
        ctl_q.host   <= cpu_wdata[B_HOST];
        ctl_q.resume <= cpu_wdata[B_RESUME];
        ctl_q.en     <= cpu_wdata[B_EN];
      end
      if (!ctl_q.host && setup_rcvd)
        susp_q <= 1'b1;
      else if (!ctl_q.host && cpu_we && !cpu_wdata[B_FLAG])
        susp_q <= 1'b0;
      sie_rst_q <= cpu_we & cpu_wdata[B_EN];
      rdata_q   <= {rx_diff ^ ls_en, rx_se0, flag_view, ctl_q.busrst,
                    ctl_q.host, ctl_q.resume, 1'b0, ctl_q.en};
    end
  end

  assign ctl       = ctl_q;
  assign bank_clr  = cpu_we & (cpu_wdata[B_ODDCLR] | cpu_wdata[B_EN]);
  assign sie_rst   = sie_rst_q;
  assign sie_halt  = susp_q & ~ctl_q.host;
  assign cpu_rdata = rdata_q;

  // R3: a SETUP in device mode arms the suspend flag
  a_r3_setup_arms: assert property (@(posedge clk) disable iff (rst)
    (setup_rcvd && !ctl_q.host) |=> susp_q);

  // R4: host mode never changes the suspend flag
  a_r4_host_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    ctl_q.host |=> $stable(susp_q));

  // R10: the engine reset is a single-cycle pulse
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    (sie_rst_q && !cpu_we) |=> !sie_rst_q);

endmodule

// File: rtl/usb_pingpong.sv
module usb_pingpong #(
  parameter int NUM_EP = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      clr,
  input  logic                      xact_done,
  input  logic [$clog2(NUM_EP)-1:0] xact_ep,
  input  logic                      xact_tx,
  input  logic [$clog2(NUM_EP)-1:0] probe_ep,
  input  logic                      probe_tx,
  output logic                      probe_odd
);

  localparam int EP_W  = $clog2(NUM_EP);
  localparam int NBITS = 2 * NUM_EP;
  localparam int IDX_W = EP_W + 1;

  logic [NBITS-1:0] bank_vec;
  logic [IDX_W-1:0] hit_idx;
  logic             probe_q;

  assign hit_idx = {xact_ep, xact_tx};

  for (genvar i = 0; i < NBITS; i++) begin : g_bank
    logic odd_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        odd_q <= 1'b0;
      else if (en && xact_done && hit_idx == IDX_W'(i))
        odd_q <= ~odd_q;
    end
    assign bank_vec[i] = odd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) probe_q <= 1'b0;
    else     probe_q <= bank_vec[{probe_ep, probe_tx}];
  end

  assign probe_odd = probe_q;

  // R9: a clear leaves every bank even
  a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bank_vec == '0));

  // R8: disabled engine keeps the banks still
  a_r8_no_toggle_off: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(bank_vec));

endmodule

// File: rtl/usb_line_sig.sv
module usb_line_sig
  import usb_ctl_pkg::*;
#(
  parameter int LS_BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic ls_en,
  output logic drv_oe,
  output logic drv_dp,
  output logic drv_dm
);

  localparam int CNT_W   = $clog2(2 * LS_BIT_CLKS);
  localparam int SE0_END = 2 * LS_BIT_CLKS - 1;
  localparam int J_END   = LS_BIT_CLKS - 1;

  line_st_e   st_q;
  logic [CNT_W-1:0] cnt_q;
  logic       bus_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        LN_IDLE: begin
          cnt_q <= '0;
          if (ctl.resume) st_q <= LN_RESUME;
        end
        LN_RESUME: begin
          cnt_q <= '0;
          if (!ctl.resume) st_q <= ctl.host ? LN_EOP_SE0 : LN_IDLE;
        end
        LN_EOP_SE0: begin
          if (cnt_q == CNT_W'(SE0_END)) begin
            st_q  <= LN_EOP_J;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        LN_EOP_J: begin
          if (cnt_q == CNT_W'(J_END)) begin
            st_q  <= LN_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= LN_IDLE;
      endcase
    end
  end

  assign bus_rst = ctl.busrst & ctl.host;

  always_comb begin
    drv_oe = 1'b0;
    drv_dp = 1'b0;
    drv_dm = 1'b0;
    if (bus_rst) begin
      drv_oe = 1'b1;
    end else begin
      unique case (st_q)
        LN_RESUME:  begin drv_oe = 1'b1; drv_dp = ls_en;  drv_dm = ~ls_en; end
        LN_EOP_SE0: begin drv_oe = 1'b1; end
        LN_EOP_J:   begin drv_oe = 1'b1; drv_dp = ~ls_en; drv_dm = ls_en;  end
        default: ;
      endcase
    end
  end

  // R5: idle line is only driven by a host bus reset
  a_r5_reset_needs_host: assert property (@(posedge clk) disable iff (rst)
    (st_q == LN_IDLE && drv_oe) |-> (ctl.busrst && ctl.host));

  // R7: a host resume release starts the end-of-packet
  a_r7_eop_follows: assert property (@(posedge clk) disable iff (rst)
    (st_q == LN_RESUME && !ctl.resume && ctl.host) |=> (st_q == LN_EOP_SE0));

  // R7: the J phase never overruns one bit time
  a_r7_j_bound: assert property (@(posedge clk) disable iff (rst)
    (st_q == LN_EOP_J) |-> (cnt_q <= CNT_W'(J_END)));

endmodule

// File: rtl/usb_ctl_sig.sv
module usb_ctl_sig
  import usb_ctl_pkg::*;
#(
  parameter int NUM_EP      = 16,
  parameter int LS_BIT_CLKS = 8,
  localparam int EP_W       = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_we,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  input  logic            rx_diff,
  input  logic            rx_se0,
  input  logic            ls_en,
  input  logic            token_busy,
  input  logic            setup_rcvd,
  output logic            sie_halt,
  output logic            sie_rst,
  output logic            usb_en,
  output logic            host_mode,
  input  logic            xact_done,
  input  logic [EP_W-1:0] xact_ep,
  input  logic            xact_tx,
  input  logic [EP_W-1:0] probe_ep,
  input  logic            probe_tx,
  output logic            probe_odd,
  output logic            drv_oe,
  output logic            drv_dp,
  output logic            drv_dm
);

  ctl_t ctl;
  logic bank_clr;

  usb_ctl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .cpu_we     (cpu_we),
    .cpu_wdata  (cpu_wdata),
    .rx_diff    (rx_diff),
    .rx_se0     (rx_se0),
    .ls_en      (ls_en),
    .token_busy (token_busy),
    .setup_rcvd (setup_rcvd),
    .ctl        (ctl),
    .bank_clr   (bank_clr),
    .sie_rst    (sie_rst),
    .sie_halt   (sie_halt),
    .cpu_rdata  (cpu_rdata)
  );

  usb_pingpong #(.NUM_EP(NUM_EP)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl.en),
    .clr       (bank_clr),
    .xact_done (xact_done),
    .xact_ep   (xact_ep),
    .xact_tx   (xact_tx),
    .probe_ep  (probe_ep),
    .probe_tx  (probe_tx),
    .probe_odd (probe_odd)
  );

  usb_line_sig #(.LS_BIT_CLKS(LS_BIT_CLKS)) u_line (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .ls_en  (ls_en),
    .drv_oe (drv_oe),
    .drv_dp (drv_dp),
    .drv_dm (drv_dm)
  );

  assign usb_en    = ctl.en;
  assign host_mode = ctl.host;

endmodule

// File: tb/tb_usb_ctl_sig.sv
module tb_usb_ctl_sig;

  localparam int LSB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       rx_diff = 1'b0, rx_se0 = 1'b0, ls_en = 1'b0;
  logic       token_busy = 1'b0, setup_rcvd = 1'b0;
  logic       sie_halt, sie_rst, usb_en, host_mode;
  logic       xact_done = 1'b0, xact_tx = 1'b0, probe_tx = 1'b0;
  logic [3:0] xact_ep = '0, probe_ep = '0;
  logic       probe_odd, drv_oe, drv_dp, drv_dm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_ctl_sig #(.NUM_EP(16), .LS_BIT_CLKS(LSB)) dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rx_diff(rx_diff), .rx_se0(rx_se0),
    .ls_en(ls_en), .token_busy(token_busy), .setup_rcvd(setup_rcvd),
    .sie_halt(sie_halt), .sie_rst(sie_rst), .usb_en(usb_en),
    .host_mode(host_mode), .xact_done(xact_done), .xact_ep(xact_ep),
    .xact_tx(xact_tx), .probe_ep(probe_ep), .probe_tx(probe_tx),
    .probe_odd(probe_odd), .drv_oe(drv_oe), .drv_dp(drv_dp), .drv_dm(drv_dm)
  );

  // {wdata, token_busy, ls_en, rx_diff, rx_se0, exp_rdata, oe, dp, dm, 0}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_2_80_0, 24'h08_8_28_0, 24'h19_6_19_8,
    24'h06_5_C4_C, 24'h2D_2_8D_A, 24'h10_8_10_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic xact(input logic [3:0] ep, input logic tx);
    @(negedge clk); xact_done = 1'b1; xact_ep = ep; xact_tx = tx;
    @(negedge clk); xact_done = 1'b0;
  endtask

  task automatic probe(input logic [3:0] ep, input logic tx, output logic v);
    @(negedge clk); probe_ep = ep; probe_tx = tx;
    @(negedge clk); v = probe_odd;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic v;
    int n_se0, n_j;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 line", {drv_oe, drv_dp, drv_dm}, 0);
    chk("R1 halt/rst", {sie_halt, sie_rst}, 0);
    probe(4'd7, 1'b1, v);
    chk("R1 bank", v, 0);

    // R2 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {token_busy, ls_en, rx_diff, rx_se0} = VEC[i][15:12];
      wr(VEC[i][23:16]);
      @(negedge clk);
      chk("R2 R4 rdata", cpu_rdata, VEC[i][11:4]);
      chk("R5 R6 line", {drv_oe, drv_dp, drv_dm}, VEC[i][3:1]);
    end
    token_busy = 1'b0; ls_en = 1'b0; rx_diff = 1'b0; rx_se0 = 1'b0;
    wr(8'h00);

    // R5 reset length follows the bit; R12 outputs
    wr(8'h18);
    chk("R5 se0 on", {drv_oe, drv_dp, drv_dm}, 3'b100);
    chk("R12 host/en", {host_mode, usb_en}, 2'b10);
    wr(8'h08);
    chk("R5 se0 off", {drv_oe, drv_dp, drv_dm}, 3'b000);

    // R3 device suspend flag
    wr(8'h01);
    chk("R10 sie_rst pulse", sie_rst, 1);
    @(negedge clk);
    chk("R10 sie_rst drop", sie_rst, 0);
    @(negedge clk); setup_rcvd = 1'b1;
    @(negedge clk); setup_rcvd = 1'b0;
    chk("R3 halt", sie_halt, 1);
    @(negedge clk);
    chk("R3 flag set", cpu_rdata[5], 1);
    wr(8'h21);
    @(negedge clk);
    chk("R3 write1 ignored", cpu_rdata[5], 1);
    wr(8'h01);
    @(negedge clk);
    chk("R3 write0 clears", {cpu_rdata[5], sie_halt}, 0);

    // R4 host mode ignores SETUP and flag writes
    wr(8'h09);
    @(negedge clk); setup_rcvd = 1'b1;
    @(negedge clk); setup_rcvd = 1'b0;
    chk("R4 no halt in host", sie_halt, 0);
    token_busy = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 busy view", cpu_rdata[5], 1);
    token_busy = 1'b0;
    wr(8'h21);
    @(negedge clk);
    chk("R4 suspend untouched", cpu_rdata[5], 0);

    // R7 host end-of-packet after resume
    wr(8'h0D);
    @(negedge clk);
    chk("R6 K fs", {drv_oe, drv_dp, drv_dm}, 3'b101);
    wr(8'h09);
    n_se0 = 0; n_j = 0;
    for (int k = 0; k < 8 * LSB; k++) begin
      @(negedge clk);
      if ({drv_oe, drv_dp, drv_dm} == 3'b100 && n_j == 0) n_se0++;
      else if ({drv_oe, drv_dp, drv_dm} == 3'b110) n_j++;
      else break;
    end
    chk("R7 eop se0 cycles", n_se0, 2 * LSB);
    chk("R7 eop j cycles", n_j, LSB);
    chk("R7 released", {drv_oe, drv_dp, drv_dm}, 3'b000);

    // R7 device release: no end-of-packet
    wr(8'h05);
    @(negedge clk);
    wr(8'h01);
    @(negedge clk);
    chk("R7 device no eop", {drv_oe, drv_dp, drv_dm}, 3'b000);

    // R8 toggling and R11 probe
    xact(4'd3, 1'b1);
    probe(4'd3, 1'b1, v); chk("R8 toggle ep3 tx", v, 1);
    probe(4'd3, 1'b0, v); chk("R11 ep3 rx even", v, 0);
    probe(4'd4, 1'b1, v); chk("R11 ep4 tx even", v, 0);
    xact(4'd3, 1'b1);
    probe(4'd3, 1'b1, v); chk("R8 toggle back", v, 0);
    xact(4'd15, 1'b0);
    xact(4'd0, 1'b1);
    probe(4'd15, 1'b0, v); chk("R8 ep15 rx", v, 1);

    // R9 odd-bank clear (disables module too)
    wr(8'h02);
    probe(4'd15, 1'b0, v); chk("R9 oddclr ep15", v, 0);
    probe(4'd0, 1'b1, v);  chk("R9 oddclr ep0", v, 0);
    xact(4'd2, 1'b0);
    probe(4'd2, 1'b0, v);  chk("R8 disabled ignored", v, 0);

    // R9 enable write clears
    wr(8'h01);
    xact(4'd9, 1'b1);
    probe(4'd9, 1'b1, v);  chk("R8 pre clear", v, 1);
    wr(8'h01);
    probe(4'd9, 1'b1, v);  chk("R9 enable clears", v, 0);

    // R9 clear beats simultaneous toggle
    @(negedge clk);
    cpu_we = 1'b1; cpu_wdata = 8'h03;
    xact_done = 1'b1; xact_ep = 4'd5; xact_tx = 1'b0;
    @(negedge clk);
    cpu_we = 1'b0; xact_done = 1'b0;
    probe(4'd5, 1'b0, v);  chk("R9 clear wins", v, 0);

    // R6 low-speed K polarity
    ls_en = 1'b1;
    wr(8'h05);
    @(negedge clk);
    chk("R6 K ls", {drv_oe, drv_dp, drv_dm}, 3'b110);

    finish_run();
  end

endmodule